// File: doc/BRIEF.md
# Receive Symbol Descrambler with Lock Watchdog

This block sits in a 100 Mb/s receive path after code-group alignment. It takes one aligned 5-bit scrambled symbol per clock and returns the descrambled symbol one clock later. While out of lock it assumes the line is idle and builds its 11-bit key state from the received bits. It declares lock once a programmable run of consecutive symbols descrambles to the idle pattern.

Once locked, the key generator runs freely and a watchdog checks lock without stopping. The watchdog counts the symbols that descramble to idle inside a fixed window of cycles. If too few arrive, the block drops lock and acquires again from the stream. A configuration input can make each such timeout appear on the receive nibble path as a one-cycle error code. A bypass input makes the output carry the raw symbols instead.

Top module: `rx_sym_descrambler`

## Requirements
- R1: While reset is asserted and right after it is released, `locked` is 0, `sym_out` is 5'h00, `rx_er` is 0 and `rxd_out` equals `rxd_in`.
- R2: The key sequence follows x^11 + x^9 + 1. Each key bit is the XOR of key-state bits 10 and 8, and that new bit is shifted into bit 0. Each symbol uses five key bits, applied to `sym_in[4]` first down to `sym_in[0]`. The descrambled bit is the received bit XOR its key bit.
- R3: While unlocked, each received bit is inverted and shifted into the key state, because idle plaintext is taken to be all ones. Lock is declared only after ACQ_RUN consecutive symbols descramble to 5'h1F. Any other symbol restarts the run, so `locked` cannot rise before ACQ_RUN symbols have been received.
- R4: While locked and not bypassed, `sym_out` one cycle after a symbol equals that symbol's plaintext, for any data pattern.
- R5: While locked, the watchdog counts symbols that descramble to 5'h1F over windows of WIN_CYC cycles. If a window ends with fewer than IDLE_MIN of them, `locked` falls on the next edge. Otherwise lock is kept and a new window starts.
- R6: After a loss of lock the block seeds its key from the stream again and relocks on a correctly scrambled idle stream.
- R7: When `cfg_pkt_err` is 1, `rx_er` is 1 and `rxd_out` is 4'h2 for exactly the cycle in which `locked` first reads 0 after a timeout. At all other times, and always when `cfg_pkt_err` is 0, `rx_er` is 0 and `rxd_out` equals `rxd_in`.
- R8: When `cfg_bypass` is 1, `sym_out` equals the previous cycle's `sym_in`. Lock tracking continues unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock, one symbol per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_in | input | 5 | Aligned scrambled symbol |
| cfg_bypass | input | 1 | Pass symbols through without descrambling |
| cfg_pkt_err | input | 1 | Report a watchdog timeout on the nibble path |
| rxd_in | input | 4 | Receive nibble from the decoder downstream |
| sym_out | output | 5 | Descrambled (or bypassed) symbol, one cycle latency |
| locked | output | 1 | Descrambler is in lock |
| rxd_out | output | 4 | Receive nibble, overridden by 4'h2 on a reported timeout |
| rx_er | output | 1 | Receive error flag for a reported timeout |

## Verification
The assertions check four things on every cycle:
- lock only rises on a symbol that descrambled to idle;
- lock only falls after the watchdog has signalled a timeout;
- the error flag always carries code 2, appears only on a loss of lock and only when reporting is enabled;
- bypass reproduces the previous input.

Some behaviour needs a reference scrambler and crafted streams, so only the bench's scenarios can show it:
- correct descrambling of arbitrary data;
- the minimum acquisition length;
- a refusal to lock on data;
- loss of lock after a key corruption, the error report at that moment, and relock.

// File: rtl/descr_pkg.sv
package descr_pkg;
  localparam int SYM_W = 5;
  localparam int KEY_W = 11;
  // taps of x^11 + x^9 + 1 within the key state
  localparam int TAP_A = KEY_W - 1;
  localparam int TAP_B = KEY_W - 3;
  localparam int NIB_W = 4;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [KEY_W-1:0] key_t;
  typedef logic [NIB_W-1:0] nib_t;

  localparam sym_t IDLE_PLAIN = '1;
  localparam nib_t TMO_CODE   = 4'h2;
endpackage

// File: rtl/descr_keystep.sv
module descr_keystep
  import descr_pkg::*;
(
  input  key_t key_cur,
  input  sym_t cipher,
  input  logic free_run,
  output sym_t plain,
  output key_t key_nxt
);
  key_t chain [SYM_W+1];
  logic [SYM_W-1:0] kbit;

  assign chain[0] = key_cur;

  // one stage per bit, most significant symbol bit first
  for (genvar g = 0; g < SYM_W; g++) begin : g_bit
    localparam int B = SYM_W - 1 - g;
    assign kbit[g]     = chain[g][TAP_A] ^ chain[g][TAP_B];
    assign plain[B]    = cipher[B] ^ kbit[g];
    assign chain[g+1]  = {chain[g][KEY_W-2:0], free_run ? kbit[g] : ~cipher[B]};
  end

  assign key_nxt = chain[SYM_W];
endmodule

// File: rtl/descr_acq.sv
module descr_acq #(
  parameter int ACQ_RUN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_idle,
  input  logic tmo,
  output logic locked
);
  localparam int CW = (ACQ_RUN > 1) ? $clog2(ACQ_RUN) : 1;
  localparam logic [CW-1:0] LAST = CW'(ACQ_RUN - 1);

  logic [CW-1:0] run_q, run_d;
  logic          lock_q, lock_d;

  always_comb begin
    run_d  = run_q;
    lock_d = lock_q;
    if (!lock_q) begin
      if (is_idle) begin
        if (run_q == LAST) begin
          lock_d = 1'b1;
          run_d  = '0;
        end else begin
          run_d = run_q + 1'b1;
        end
      end else begin
        run_d = '0;
      end
    end else if (tmo) begin
      lock_d = 1'b0;
      run_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;
endmodule

// File: rtl/descr_mon.sv
module descr_mon #(
  parameter int WIN_CYC  = 18050,
  parameter int IDLE_MIN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic is_idle,
  output logic tmo
);
  localparam int WW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int IW = $clog2(IDLE_MIN + 1);
  localparam logic [WW-1:0] WLAST = WW'(WIN_CYC - 1);
  localparam logic [IW:0]   IMIN  = (IW+1)'(IDLE_MIN);

  logic [WW-1:0] win_q, win_d;
  logic [IW-1:0] idl_q, idl_d;
  logic [IW:0]   idl_sum;
  logic          last;

  assign idl_sum = {1'b0, idl_q} + {{IW{1'b0}}, is_idle};
  assign last    = active && (win_q == WLAST);
  assign tmo     = last && (idl_sum < IMIN);

  always_comb begin
    win_d = win_q;
    idl_d = idl_q;
    if (!active || last) begin
      win_d = '0;
      idl_d = '0;
    end else begin
      win_d = win_q + 1'b1;
      if (idl_sum <= IMIN) idl_d = idl_sum[IW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      idl_q <= '0;
    end else begin
      win_q <= win_d;
      idl_q <= idl_d;
    end
  end
endmodule

// File: rtl/rx_sym_descrambler.sv
module rx_sym_descrambler
  import descr_pkg::*;
#(
  parameter int ACQ_RUN  = 8,
  parameter int WIN_CYC  = 18050,
  parameter int IDLE_MIN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] sym_in,
  input  logic       cfg_bypass,
  input  logic       cfg_pkt_err,
  input  logic [3:0] rxd_in,
  output logic [4:0] sym_out,
  output logic       locked,
  output logic [3:0] rxd_out,
  output logic       rx_er
);
  key_t key_q, key_d;
  sym_t plain, sym_q, sym_d;
  logic err_q, err_d;
  logic is_idle, mon_tmo, lock_w;

  descr_keystep u_step (
    .key_cur (key_q),
    .cipher  (sym_in),
    .free_run(lock_w),
    .plain   (plain),
    .key_nxt (key_d)
  );

  assign is_idle = (plain == IDLE_PLAIN);

  descr_acq #(.ACQ_RUN(ACQ_RUN)) u_acq (
    .clk    (clk),
    .rst_n  (rst_n),
    .is_idle(is_idle),
    .tmo    (mon_tmo),
    .locked (lock_w)
  );

  descr_mon #(.WIN_CYC(WIN_CYC), .IDLE_MIN(IDLE_MIN)) u_mon (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (lock_w),
    .is_idle(is_idle),
    .tmo    (mon_tmo)
  );

  always_comb begin
    sym_d = cfg_bypass ? sym_in : plain;
    err_d = mon_tmo && cfg_pkt_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      sym_q <= '0;
      err_q <= 1'b0;
    end else begin
      key_q <= key_d;
      sym_q <= sym_d;
      err_q <= err_d;
    end
  end

  assign sym_out = sym_q;
  assign locked  = lock_w;
  assign rx_er   = err_q;
  assign rxd_out = err_q ? TMO_CODE : rxd_in;
endmodule

// File: rtl/descr_chk.sv
module descr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] sym_in,
  input logic       cfg_bypass,
  input logic       cfg_pkt_err,
  input logic [4:0] sym_out,
  input logic       locked,
  input logic [3:0] rxd_out,
  input logic       rx_er,
  input logic       tmo
);
  // R3: lock rises only on a symbol that descrambled to idle
  a_r3_rise_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(locked) && !$past(cfg_bypass)) |-> (sym_out == 5'h1F));

  // R5: lock falls only after a watchdog timeout
  a_r5_fall_needs_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(tmo));

  // R7: error flag appears only on a loss of lock
  a_r7_err_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er |-> (!locked && $past(locked)));

  // R7: the flag always carries the timeout code
  a_r7_err_code: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er |-> (rxd_out == 4'h2));

  // R7: no report while reporting is disabled
  a_r7_err_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er |-> $past(cfg_pkt_err));

  // R8: bypass forwards the previous input
  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_bypass) |-> (sym_out == $past(sym_in)));
endmodule

bind rx_sym_descrambler descr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sym_in     (sym_in),
  .cfg_bypass (cfg_bypass),
  .cfg_pkt_err(cfg_pkt_err),
  .sym_out    (sym_out),
  .locked     (locked),
  .rxd_out    (rxd_out),
  .rx_er      (rx_er),
  .tmo        (mon_tmo)
);

// File: tb/rx_sym_descrambler_tb.sv
module rx_sym_descrambler_tb;
  localparam int ACQ = 4;
  localparam int WIN = 64;
  localparam int IMN = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] sym_in = '0;
  logic       cfg_bypass = 1'b0;
  logic       cfg_pkt_err = 1'b0;
  logic [3:0] rxd_in = '0;
  logic [4:0] sym_out;
  logic       locked;
  logic [3:0] rxd_out;
  logic       rx_er;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [10:0] tx_key = 11'h6B5;
  logic [4:0]  last_c;

  always #2 clk = ~clk;

  rx_sym_descrambler #(.ACQ_RUN(ACQ), .WIN_CYC(WIN), .IDLE_MIN(IMN)) u_dut (
    .clk(clk), .rst_n(rst_n), .sym_in(sym_in), .cfg_bypass(cfg_bypass),
    .cfg_pkt_err(cfg_pkt_err), .rxd_in(rxd_in), .sym_out(sym_out),
    .locked(locked), .rxd_out(rxd_out), .rx_er(rx_er)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference scrambler: x^11 + x^9 + 1, bit 4 first (R2)
  function automatic logic [4:0] scramble(input logic [4:0] p);
    logic [4:0] c;
    logic kb;
    for (int i = 4; i >= 0; i--) begin
      kb     = tx_key[10] ^ tx_key[8];
      c[i]   = p[i] ^ kb;
      tx_key = {tx_key[9:0], kb};
    end
    return c;
  endfunction

  task automatic send(input logic [4:0] p, input bit chk_pl, input string req);
    last_c = scramble(p);
    sym_in = last_c;
    rxd_in = 4'($urandom);
    @(posedge clk);
    #1;
    if (chk_pl) chk(sym_out == p, req, sym_out, p);
  endtask

  function automatic logic [4:0] rnd_data();
    logic [4:0] v;
    v = 5'($urandom);
    if (v == 5'h1F) v = 5'h0E;
    return v;
  endfunction

  task automatic loss_test(input bit report);
    int cyc = 0;
    bit seen = 1'b0;
    cfg_pkt_err = report;
    tx_key = tx_key ^ 11'h400;
    if (tx_key == '0) tx_key = 11'h1;
    while (!seen && cyc < 3*WIN) begin
      send(5'h1F, 1'b0, "");
      cyc++;
      if (!locked) begin
        seen = 1'b1;
        chk(cyc <= 2*WIN + 2, "R5 loss within two windows", cyc, 2*WIN + 2);
        if (report) begin
          chk(rx_er == 1'b1, "R7 rx_er on timeout", rx_er, 1);
          chk(rxd_out == 4'h2, "R7 code 2 on timeout", rxd_out, 2);
        end else begin
          chk(rx_er == 1'b0, "R7 rx_er off when disabled", rx_er, 0);
          chk(rxd_out == rxd_in, "R7 passthrough when disabled", rxd_out, rxd_in);
        end
      end
    end
    chk(seen, "R5 lock lost after corruption", locked, 0);
    send(5'h1F, 1'b0, "");
    chk(rx_er == 1'b0, "R7 error lasts one cycle", rx_er, 0);
    for (int i = 0; i < 20; i++) send(5'h1F, 1'b0, "");
    chk(locked == 1'b1, "R6 relock on idle", locked, 1);
    for (int i = 0; i < 8; i++) send(rnd_data(), 1'b1, "R6 data after relock");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R5 watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk(locked == 1'b0, "R1 locked in reset", locked, 0);
    chk(sym_out == 5'h00, "R1 sym_out in reset", sym_out, 0);
    chk(rx_er == 1'b0, "R1 rx_er in reset", rx_er, 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(locked == 1'b0, "R1 locked after release", locked, 0);
    chk(rxd_out == rxd_in, "R1 rxd passthrough", rxd_out, rxd_in);

    // R3: data only, never locks
    for (int i = 0; i < 40; i++) send(rnd_data(), 1'b0, "");
    chk(locked == 1'b0, "R3 no lock on data", locked, 0);

    // R3: too short an idle run
    for (int i = 0; i < ACQ - 1; i++) send(5'h1F, 1'b0, "");
    chk(locked == 1'b0, "R3 no lock before run length", locked, 0);
    for (int i = 0; i < 30; i++) send(5'h1F, 1'b0, "");
    chk(locked == 1'b1, "R3 lock after idle run", locked, 1);
    for (int i = 0; i < 4; i++) send(5'h1F, 1'b1, "R2 idle descrambles to 1F");

    // R4, R5: framed data with enough idles keeps lock
    for (int b = 0; b < 6; b++) begin
      for (int i = 0; i < 20; i++) send(5'($urandom), 1'b1, "R4 data descramble");
      for (int i = 0; i < 12; i++) send(5'h1F, 1'b1, "R4 idle descramble");
    end
    chk(locked == 1'b1, "R5 lock held with enough idles", locked, 1);

    // R5, R6, R7: corruption with reporting enabled, then disabled
    loss_test(1'b1);
    loss_test(1'b0);

    // R8: bypass
    cfg_bypass = 1'b1;
    for (int i = 0; i < 10; i++) begin
      send(5'($urandom), 1'b0, "");
      chk(sym_out == last_c, "R8 bypass output", sym_out, last_c);
    end
    cfg_bypass = 1'b0;
    chk(locked == 1'b1, "R8 lock kept through bypass", locked, 1);
    for (int i = 0; i < 6; i++) send(5'($urandom), 1'b1, "R8 descramble after bypass");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule